// File: doc/BRIEF.md
# JTAG Clock Rate Configurator

This block turns a requested JTAG clock rate, given in hertz as a 32-bit value, into the number of timer cycles that one half of the JTAG clock period should last. It also provides the matching half-period wait timer for the engines that shift JTAG data. A requester raises `req_valid` for one cycle with the rate on `req_hz`. The block divides the timer frequency (a parameter) by the rate with a sequential divider and halves the result. It then removes a fixed per-edge overhead and limits the result to a range that a signed 16-bit countdown can hold. It answers with a one-cycle `rsp_valid` and a status byte.

The active half-period count sits in a register and is visible on `half_count`. A shifting engine starts a wait with `wait_start`. The timer adds the count to a free-running 16-bit tick counter to form a deadline. It pulses `wait_done` once the signed difference between the tick counter and the deadline stops being negative, so the wait stays correct when the tick counter wraps.

Top module: `jtag_rate_cfg`

## Requirements
- R1: After reset `half_count` equals TIMER_HZ/100000/2 − 50 (350 with the default 80 MHz timer), and `busy` and `rsp_valid` are low.
- R2: A nonzero rate F stores floor(TIMER_HZ/F/2) − 50 in `half_count` and returns status 0x00.
- R3: When floor(TIMER_HZ/F/2) is 50 or less, the stored count is 0 and the status is 0x00.
- R4: A rate of 0 returns status 0xFF and leaves `half_count` unchanged.
- R5: A result of 0x8000 or more returns status 0xFF and leaves `half_count` unchanged.
- R6: `busy` is high from the cycle after a nonzero request is accepted until the response. Every accepted request produces exactly one `rsp_valid` pulse, one cycle long.
- R7: A request raised while `busy` is high is ignored. It produces no response and does not change `half_count`.
- R8: After `wait_start` is sampled at a clock edge, `wait_done` is high for exactly one cycle, following the max(C,1)-th later edge, where C is `half_count`.
- R9: The wait length in R8 stays exact when the 16-bit tick counter wraps during the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Rate request strobe, accepted when not busy |
| req_hz | input | 32 | Requested JTAG clock rate in Hz |
| busy | output | 1 | Division in progress; requests are ignored |
| rsp_valid | output | 1 | One-cycle pulse carrying the status |
| rsp_status | output | 8 | 0x00 success, 0xFF rejected |
| half_count | output | 16 | Active half-period count in timer cycles |
| wait_start | input | 1 | Starts a half-period wait |
| wait_done | output | 1 | One-cycle pulse when the wait has elapsed |

## Verification
The hardest case to reach is a wait that spans the wrap of the 16-bit tick counter. The tick counter is not visible and only wraps after 65536 cycles. To reach it, the bench programs a half-period near 30000 cycles and runs three waits back to back. Together they cover more than a full tick period, so one of them must cross the wrap, and each wait's exact length is checked. The boundaries around the overhead clamp and the 0x8000 limit use rates chosen from the same integer formula.

// File: rtl/jrc_pkg.sv
// Package: shared constants for the JTAG clock rate configurator.
// Assumes: status byte values are fixed by the command protocol.
package jrc_pkg;
    localparam logic [7:0] ST_OK  = 8'h00;
    localparam logic [7:0] ST_ERR = 8'hFF;
    localparam int         CNT_W  = 16;
endpackage

// File: rtl/jrc_divider.sv
// Module: jrc_divider
// Restoring unsigned divider, one quotient bit per cycle.
// Assumes: divisor is nonzero when start is raised; start is ignored while busy.
module jrc_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient
);
    localparam int CW = $clog2(W + 1);

    logic [W:0]    rem_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  dsr_q;
    logic [CW-1:0] left_q;
    logic [W:0]    rem_sh;
    logic          fits;

    // Trial subtraction for the current step.
    always_comb begin
        rem_sh = {rem_q[W-1:0], quo_q[W-1]};
        fits   = (rem_sh >= {1'b0, dsr_q});
    end

    // Step through the quotient bits and flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dsr_q  <= '0;
            left_q <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy && start) begin
                rem_q  <= '0;
                quo_q  <= dividend;
                dsr_q  <= divisor;
                left_q <= CW'(W);
                busy   <= 1'b1;
            end else if (busy) begin
                rem_q  <= fits ? (rem_sh - {1'b0, dsr_q}) : rem_sh;
                quo_q  <= {quo_q[W-2:0], fits};
                left_q <= left_q - 1'b1;
                if (left_q == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quotient = quo_q;

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
endmodule

// File: rtl/jrc_rate_reg.sv
// Module: jrc_rate_reg
// Turns a quotient into a half-period count, applies overhead, clamp and
// range check, and holds the active count and the response.
// Assumes: div_done and zero_req are never high together.
module jrc_rate_reg
    import jrc_pkg::*;
#(
    parameter int W         = 32,
    parameter int TIMER_HZ  = 80_000_000,
    parameter int RESET_HZ  = 100_000,
    parameter int OVERHEAD  = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_done,
    input  logic [W-1:0]     quotient,
    input  logic             zero_req,
    output logic             rsp_valid,
    output logic [7:0]       rsp_status,
    output logic [CNT_W-1:0] half_count
);
    localparam int LIMIT     = 1 << (CNT_W - 1);
    localparam int RST_HALF  = TIMER_HZ / RESET_HZ / 2;
    localparam int RST_COUNT = (RST_HALF > OVERHEAD) ? (RST_HALF - OVERHEAD) : 0;

    logic [W-1:0] half_raw;
    logic [W-1:0] adj;
    logic         in_range;

    // Halve, remove the overhead with a floor at zero, check the range.
    always_comb begin
        half_raw = quotient >> 1;
        adj      = (half_raw <= W'(OVERHEAD)) ? '0 : (half_raw - W'(OVERHEAD));
        in_range = (adj < W'(LIMIT));
    end

    // Commit the count on success and present the status for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_count <= CNT_W'(RST_COUNT);
            rsp_valid  <= 1'b0;
            rsp_status <= ST_OK;
        end else begin
            rsp_valid <= div_done | zero_req;
            if (zero_req) begin
                rsp_status <= ST_ERR;
            end else if (div_done) begin
                rsp_status <= in_range ? ST_OK : ST_ERR;
                if (in_range) half_count <= adj[CNT_W-1:0];
            end
        end
    end

    AST_KEEP_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == ST_ERR) |-> $stable(half_count)); // R4
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !half_count[CNT_W-1]); // R5
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R6
endmodule

// File: rtl/jrc_half_timer.sv
// Module: jrc_half_timer
// Half-period wait timer on a free-running 16-bit tick counter; the
// deadline compare uses the signed difference so it tolerates wrap.
// Assumes: count stays below 0x8000; a new start reloads the deadline.
module jrc_half_timer
    import jrc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] count,
    output logic             done
);
    logic [CNT_W-1:0] tick_q;
    logic [CNT_W-1:0] target_q;
    logic             waiting_q;
    logic [CNT_W-1:0] diff;

    // Distance from deadline; top bit set means not yet reached.
    always_comb diff = tick_q - target_q;

    // Run the tick counter, load deadlines and raise the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q    <= '0;
            target_q  <= '0;
            waiting_q <= 1'b0;
            done      <= 1'b0;
        end else begin
            tick_q <= tick_q + 1'b1;
            done   <= 1'b0;
            if (start) begin
                target_q  <= tick_q + count;
                waiting_q <= 1'b1;
            end else if (waiting_q && !diff[CNT_W-1]) begin
                waiting_q <= 1'b0;
                done      <= 1'b1;
            end
        end
    end

    AST_WAIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_NEEDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(waiting_q)); // R8
endmodule

// File: rtl/jtag_rate_cfg.sv
// Module: jtag_rate_cfg (top)
// Accepts a JTAG rate request, derives the half-period count with a
// sequential divider and provides the half-period wait timer.
// Assumes: requests raised while busy are dropped by design.
module jtag_rate_cfg
    import jrc_pkg::*;
#(
    parameter int TIMER_HZ = 80_000_000,
    parameter int RESET_HZ = 100_000,
    parameter int OVERHEAD = 50,
    parameter int HZ_W     = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [HZ_W-1:0]  req_hz,
    output logic             busy,
    output logic             rsp_valid,
    output logic [7:0]       rsp_status,
    output logic [CNT_W-1:0] half_count,
    input  logic             wait_start,
    output logic             wait_done
);
    logic            div_busy;
    logic            div_done;
    logic [HZ_W-1:0] quotient;
    logic            accept;
    logic            zero_req_q;

    // A request is taken only when no division or response is pending.
    always_comb begin
        busy   = div_busy | div_done;
        accept = req_valid && !busy && !zero_req_q;
    end

    // Zero rates skip the divider and answer on the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) zero_req_q <= 1'b0;
        else        zero_req_q <= accept && (req_hz == '0);
    end

    jrc_divider #(.W(HZ_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept && (req_hz != '0)),
        .dividend (HZ_W'(TIMER_HZ)),
        .divisor  (req_hz),
        .busy     (div_busy),
        .done     (div_done),
        .quotient (quotient)
    );

    jrc_rate_reg #(
        .W        (HZ_W),
        .TIMER_HZ (TIMER_HZ),
        .RESET_HZ (RESET_HZ),
        .OVERHEAD (OVERHEAD)
    ) u_rate (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_done   (div_done),
        .quotient   (quotient),
        .zero_req   (zero_req_q),
        .rsp_valid  (rsp_valid),
        .rsp_status (rsp_status),
        .half_count (half_count)
    );

    jrc_half_timer u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wait_start),
        .count (half_count),
        .done  (wait_done)
    );

    AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !div_done) |=> !zero_req_q); // R7
endmodule

// File: tb/jtag_rate_cfg_tb.sv
module jtag_rate_cfg_tb;
    localparam int TIMER_HZ = 80_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_hz = '0;
    logic        busy;
    logic        rsp_valid;
    logic [7:0]  rsp_status;
    logic [15:0] half_count;
    logic        wait_start = 1'b0;
    logic        wait_done;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    int exp_count = 350;

    always #2 clk = ~clk;

    jtag_rate_cfg u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hz(req_hz),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
        .half_count(half_count), .wait_start(wait_start), .wait_done(wait_done)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model(input longint hz, output bit ok);
        longint h;
        h = (TIMER_HZ / hz) / 2;
        h = (h <= 50) ? 0 : h - 50;
        ok = (h < 32768);
        return int'(h);
    endfunction

    // Issue one request and check busy, status, pulse width and count.
    task automatic t_rate(input string req, input longint hz);
        bit ok;
        int c;
        int n;
        c = (hz == 0) ? 0 : model(hz, ok);
        if (hz == 0) ok = 1'b0;
        @(negedge clk); req_valid = 1'b1; req_hz = 32'(hz);
        @(negedge clk); req_valid = 1'b0;
        if (hz != 0) check({req, " R6 busy"}, busy, 1);
        n = 0;
        while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
        check({req, " R6 rsp_valid"}, rsp_valid, 1);
        check({req, " status"}, rsp_status, ok ? 8'h00 : 8'hFF);
        if (ok) exp_count = c;
        check({req, " half_count"}, half_count, exp_count);
        @(negedge clk);
        check({req, " R6 single pulse"}, rsp_valid, 0);
    endtask

    // Second request during a division must vanish.
    task automatic t_busy_ignore();
        bit ok;
        int c;
        int n;
        int seen;
        c = model(400_000, ok);
        @(negedge clk); req_valid = 1'b1; req_hz = 32'd400_000;
        @(negedge clk); req_hz = 32'd0;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        seen = 0;
        for (int i = 0; i < 80; i++) begin
            if (rsp_valid) begin
                seen++;
                check("R7 status of first", rsp_status, 8'h00);
            end
            @(negedge clk);
        end
        check("R7 response count", seen, 1);
        exp_count = c;
        check("R7 half_count", half_count, c);
    endtask

    // Time a wait in clock edges after the start edge.
    task automatic t_wait(input string req);
        int k;
        int exp;
        exp = (exp_count < 1) ? 1 : exp_count;
        @(negedge clk); wait_start = 1'b1;
        @(negedge clk); wait_start = 1'b0;
        k = 0;
        while (!wait_done && k < 40000) begin @(negedge clk); k++; end
        check({req, " wait length"}, k, exp);
        @(negedge clk);
        check({req, " wait pulse"}, wait_done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset count", half_count, 350);
        check("R1 reset busy", busy, 0);
        check("R1 reset rsp", rsp_valid, 0);
        t_wait("R8 default");
        t_rate("R2 1MHz", 1_000_000);
        t_rate("R2 250kHz", 250_000);
        t_wait("R8 after update");
        t_rate("R3 clamp edge 800kHz", 800_000);
        t_wait("R8 zero count");
        t_rate("R3 one above 780kHz", 780_000);
        t_rate("R3 above timer", 200_000_000);
        t_rate("R4 zero rate", 0);
        t_rate("R5 1kHz too slow", 1000);
        t_rate("R5 1Hz", 1);
        t_rate("R5 edge 1219Hz", 1219);
        t_busy_ignore();
        t_rate("R9 setup 1333Hz", 1333);
        t_wait("R9 long a");
        t_wait("R9 long b");
        t_wait("R9 long c wrap");
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule